// File: doc/BRIEF.md
# Key-Guarded Alternate-Function Select

This block protects a per-pin alternate-function select register with two stages of write protection. The first stage is a lock that opens only when one exact 32-bit key value is written to the lock register with every byte lane enabled. Any other write to that register closes the lock again. The second stage is a per-bit commit mask. The mask can be reloaded only while the lock is open. Once loaded, it decides which bits of the alternate-function register a write may change.

Software opens the lock and writes the commit mask. It then closes the lock, and from that point writes to the select register reach only the committed bits. Reads of all three registers work at any time. The select value also leaves the block on a dedicated output, so pad logic can use it.

Top module: `afgate_top`

## Requirements
- R1: After reset the lock reads 1 (locked), the commit mask reads all ones in its AF_W low bits, and the select register reads 0.
- R2: A write to the lock offset (0x520) with data 0x0ACCE551 and all byte strobes set opens the lock, and the lock then reads 0.
- R3: A write to the lock offset with any other data value, or with any byte strobe clear, closes the lock, and the lock then reads 1.
- R4: A write to the commit offset (0x524) loads the low AF_W data bits into the commit mask while the lock is open. While the lock is closed, such a write leaves the mask unchanged.
- R5: A write to the select offset (0x420) with data v turns the select value s into (s & ~c) | (v & c), where c is the commit mask.
- R6: The select and commit registers read back zero-extended in both lock states. Reads of any unmapped offset return 0.
- R7: Writes to unmapped offsets change none of the three registers.
- R8: The af_sel output always equals the select register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset used for both read and write |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_wstrb | input | DATA_W/8 | Byte-lane enables; only the lock register uses them |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| af_sel | output | AF_W | Current alternate-function select value |

## Verification
The bench builds the block with AF_W = 4, so it can sweep every commit mask against every write value to the select register, with the expected values computed in the bench. With 32-bit data it also flips each key bit in turn and tries every partial strobe pattern, which covers every way a near-miss key should close the lock.

// File: rtl/afgate_pkg.sv
package afgate_pkg;
    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_LOCK,
        TGT_COMMIT,
        TGT_SEL
    } afg_tgt_e;
endpackage

// File: rtl/afgate_lock.sv
module afgate_lock #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = 32'h0ACC_E551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              full_strb_i,
    output logic              locked_o
);
    typedef struct packed {
        logic locked;
    } lock_state_t;

    lock_state_t st_d, st_q;
    logic        key_hit;

    always_comb begin
        key_hit = full_strb_i && (wdata_i == DATA_W'(KEY));
        st_d    = st_q;
        if (wr_i) begin
            st_d.locked = !key_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;

    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_strb_i && wdata_i == DATA_W'(KEY)) |=> !locked_o);
    a_r3_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (!full_strb_i || wdata_i != DATA_W'(KEY))) |=> locked_o);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(locked_o));
endmodule

// File: rtl/afgate_commit.sv
module afgate_commit #(
    parameter int AF_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            locked_i,
    input  logic [AF_W-1:0] wdata_i,
    output logic [AF_W-1:0] mask_o
);
    typedef struct packed {
        logic [AF_W-1:0] mask;
    } commit_state_t;

    commit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && !locked_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

    a_r4_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && locked_i) |=> $stable(mask_o));
    a_r4_open_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !locked_i) |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/afgate_masked_reg.sv
module afgate_masked_reg #(
    parameter int AF_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [AF_W-1:0] mask_i,
    input  logic [AF_W-1:0] wdata_i,
    output logic [AF_W-1:0] q_o
);
    typedef struct packed {
        logic [AF_W-1:0] sel;
    } sel_state_t;

    sel_state_t      st_d, st_q;
    logic [AF_W-1:0] bit_next;

    for (genvar i = 0; i < AF_W; i++) begin : g_bit
        always_comb begin
            bit_next[i] = (wr_i && mask_i[i]) ? wdata_i[i] : st_q.sel[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.sel = bit_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.sel;

    a_r5_uncommitted_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0));
    a_r5_committed_taken: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (((q_o ^ $past(wdata_i)) & $past(mask_i)) == '0));
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(q_o));
endmodule

// File: rtl/afgate_top.sv
module afgate_top #(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          AF_W       = 8,
    parameter logic [31:0] KEY        = 32'h0ACC_E551,
    parameter logic [11:0] LOCK_OFS   = 12'h520,
    parameter logic [11:0] COMMIT_OFS = 12'h524,
    parameter logic [11:0] SEL_OFS    = 12'h420
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wen,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_wstrb,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [AF_W-1:0]     af_sel
);
    import afgate_pkg::*;

    localparam int STRB_W = DATA_W / 8;

    afg_tgt_e        tgt;
    logic            locked;
    logic [AF_W-1:0] commit_mask;
    logic [AF_W-1:0] sel_q;
    logic            full_strb;

    always_comb begin
        if (bus_addr == ADDR_W'(LOCK_OFS))        tgt = TGT_LOCK;
        else if (bus_addr == ADDR_W'(COMMIT_OFS)) tgt = TGT_COMMIT;
        else if (bus_addr == ADDR_W'(SEL_OFS))    tgt = TGT_SEL;
        else                                      tgt = TGT_NONE;
        full_strb = (bus_wstrb == {STRB_W{1'b1}});
    end

    afgate_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wen && tgt == TGT_LOCK),
        .wdata_i     (bus_wdata),
        .full_strb_i (full_strb),
        .locked_o    (locked)
    );

    afgate_commit #(.AF_W(AF_W)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wen && tgt == TGT_COMMIT),
        .locked_i (locked),
        .wdata_i  (bus_wdata[AF_W-1:0]),
        .mask_o   (commit_mask)
    );

    afgate_masked_reg #(.AF_W(AF_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wen && tgt == TGT_SEL),
        .mask_i  (commit_mask),
        .wdata_i (bus_wdata[AF_W-1:0]),
        .q_o     (sel_q)
    );

    always_comb begin
        unique case (tgt)
            TGT_LOCK:   bus_rdata = DATA_W'(locked);
            TGT_COMMIT: bus_rdata = DATA_W'(commit_mask);
            TGT_SEL:    bus_rdata = DATA_W'(sel_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign af_sel = sel_q;

    a_r7_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && tgt == TGT_NONE) |=> ($stable(af_sel) && $stable(commit_mask) && $stable(locked)));
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_afgate_top.sv
module tb_afgate_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W = 12;
    localparam int          DATA_W = 32;
    localparam int          AF_W   = 4;
    localparam int          STRB_W = DATA_W / 8;
    localparam logic [31:0] KEY    = 32'h0ACC_E551;
    localparam logic [11:0] A_LOCK = 12'h520;
    localparam logic [11:0] A_CMT  = 12'h524;
    localparam logic [11:0] A_SEL  = 12'h420;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic                bus_wen = 1'b0;
    logic [DATA_W-1:0]   bus_wdata = '0;
    logic [STRB_W-1:0]   bus_wstrb = '0;
    logic [DATA_W-1:0]   bus_rdata;
    logic [AF_W-1:0]     af_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    afgate_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AF_W(AF_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .bus_rdata (bus_rdata),
        .af_sel    (af_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [STRB_W-1:0] s);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wstrb = s;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wen  = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [AF_W-1:0] model;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_LOCK, r); check("R1 lock", r, 32'd1);
        rd(A_CMT, r);  check("R1 commit", r, 32'hF);
        rd(A_SEL, r);  check("R1 sel", r, 32'd0);
        check("R8 af_sel reset", 32'(af_sel), 32'd0);

        // R4 commit ignored while locked
        wr(A_CMT, 32'h5, '1);
        rd(A_CMT, r); check("R4 locked commit write ignored", r, 32'hF);

        // R2 key opens
        wr(A_LOCK, KEY, '1);
        rd(A_LOCK, r); check("R2 unlocked", r, 32'd0);

        // R3 each single-bit corruption of the key closes
        for (int b = 0; b < 32; b++) begin
            wr(A_LOCK, KEY, '1);
            wr(A_LOCK, KEY ^ (32'd1 << b), '1);
            rd(A_LOCK, r); check("R3 flipped key bit", r, 32'd1);
        end
        // R3 every partial strobe closes
        for (int s = 0; s < (1 << STRB_W) - 1; s++) begin
            wr(A_LOCK, KEY, '1);
            wr(A_LOCK, KEY, STRB_W'(s));
            rd(A_LOCK, r); check("R3 partial strobe", r, 32'd1);
        end

        // R5/R6/R8 sweep all commit masks and write values
        model = '0;
        for (int c = 0; c < 16; c++) begin
            wr(A_LOCK, KEY, '1);
            wr(A_CMT, 32'hFFFF_FFF0 | 32'(c), '1);
            rd(A_CMT, r); check("R4 open commit load", r, 32'(c));
            wr(A_LOCK, 32'h0, '1);
            rd(A_CMT, r); check("R6 commit read while locked", r, 32'(c));
            for (int v = 0; v < 16; v++) begin
                wr(A_SEL, 32'hA5A5_A5A0 | 32'(v), '1);
                model = (model & ~AF_W'(c)) | (AF_W'(v) & AF_W'(c));
                rd(A_SEL, r); check("R5 masked select write", r, 32'(model));
                check("R8 af_sel output", 32'(af_sel), 32'(model));
            end
        end

        // R6 select read while unlocked
        wr(A_LOCK, KEY, '1);
        rd(A_SEL, r); check("R6 select read while unlocked", r, 32'(model));

        // R7 stray writes change nothing; R6 unmapped reads give 0
        wr(A_CMT, 32'h9, '1);
        wr(12'h000, 32'hFFFF_FFFF, '1);
        wr(12'h41C, 32'hFFFF_FFFF, '1);
        wr(12'h528, 32'h0, '1);
        rd(A_LOCK, r); check("R7 lock untouched", r, 32'd0);
        rd(A_CMT, r);  check("R7 commit untouched", r, 32'h9);
        rd(A_SEL, r);  check("R7 select untouched", r, 32'(model));
        rd(12'h000, r); check("R6 unmapped read", r, 32'd0);
        rd(12'h41C, r); check("R6 unmapped read", r, 32'd0);

        finish_run();
    end
endmodule